// File: doc/BRIEF.md
# Thread Scheduler Table with Linked Queues

This block holds the per-thread context of a multithreaded pipeline: a program counter, a register-file base and one link field per entry. The thread identifier is a direct index into the table. No entry stores a state field. A thread's state is given only by the linked list it belongs to:

- the free list (unallocated);
- the run queue (active);
- a one-entry slot owned by the register the thread blocked on (suspended);
- a per-cache-line wait list (waiting).

Each list's head and tail pointers live beside the structure that owns the list.

**Thread creation** is a valid/ready stream. `create_ready` is high while the free list has an entry. `create_tid` names the entry that a transfer in this cycle will take. A transfer happens on a clock edge where both `create_valid` and `create_ready` are high. While `create_ready` is low the creator must hold its request.

**Issue** is a valid/ready stream as well. `issue_valid` is high while the run queue is non-empty, and the head thread is presented. The pipeline accepts the head by raising `issue_ready`. In that same cycle it supplies the outcome of the operand read, the next program counter and, for a block, the register number. While `issue_ready` is low the head stays in place.

**Other inputs.** Register write-backs (wake-ups) and cache-line returns are plain single-cycle events with no back-pressure. For a wake-up, `wake_pc` is presented so that the instruction cache can answer hit or miss in the same cycle. The `idle` output allows the processor clock to be gated when nothing can issue.

Top module: `tt_thread_queues`

## Requirements
- R1: After reset `idle` is 1, `issue_valid` is 0 and `create_ready` is 1. The free list holds every thread in ascending index order, so the first creation receives thread 0.
- R2: A creation transfer takes the free-list head, stores the supplied PC and base, and appends that thread to the run-queue tail. At most one creation completes per clock. A request made while `create_ready` is 0 has no effect.
- R3: `issue_valid` is 1 exactly when the run queue is non-empty. `issue_tid`, `issue_pc` and `issue_base` show the head thread. While `issue_ready` is 0 the head and the queue are unchanged.
- R4: Outcome code 0 (requeue; code 3 behaves the same) moves the issued thread to the run-queue tail and stores `issue_npc` as its PC.
- R5: Outcome code 1 (suspend) removes the issued thread from the run queue and parks it in the slot of register `issue_reg`, storing `issue_npc`. The thread is not issued while it is parked.
- R6: A wake-up naming a register that holds a thread asserts `wake_found`, presents that thread's PC on `wake_pc` and empties the slot. On a hit the thread joins the run-queue tail. On a miss it joins the tail of the wait list of line `wake_line`. A wake-up on an empty slot shows `wake_found` 0 and changes no queue.
- R7: A line return appends the whole wait list of that line to the run-queue tail in one cycle, keeping the list's order. A return for a line with no waiting thread has no effect.
- R8: Outcome code 2 (retire) puts the issued thread at the free-list tail, so threads are re-allocated in the order they were retired.
- R9: When several events append to the run queue in one cycle, they land in this order: requeue of the issued thread, woken thread, created thread, returned wait list.
- R10: If the issued thread suspends on the same register that a wake-up names in that cycle, and that slot is empty, the thread is treated as woken at once. `wake_found` is 1, `wake_pc` equals `issue_npc`, and the slot stays empty.
- R11: `idle` is 1 exactly when the run queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| create_valid | input | 1 | Creation request |
| create_ready | output | 1 | Free list non-empty |
| create_pc | input | PC_W | Start PC of the new thread |
| create_base | input | BASE_W | Register-file base of the new thread |
| create_tid | output | TID_W | Index a creation in this cycle receives |
| issue_valid | output | 1 | Run queue non-empty |
| issue_ready | input | 1 | Pipeline accepts the head thread |
| issue_tid | output | TID_W | Head thread index |
| issue_pc | output | PC_W | Head thread PC |
| issue_base | output | BASE_W | Head thread register base |
| issue_outcome | input | 2 | 0 requeue, 1 suspend, 2 retire, 3 requeue |
| issue_reg | input | REG_W | Register the issued thread blocks on |
| issue_npc | input | PC_W | PC to store for the issued thread |
| wake_valid | input | 1 | Register write-back event |
| wake_reg | input | REG_W | Register written |
| wake_found | output | 1 | A thread is woken by this event |
| wake_pc | output | PC_W | PC of the woken thread, for the cache lookup |
| wake_hit | input | 1 | Cache result for `wake_pc` |
| wake_line | input | LINE_W | Cache line that a missing thread waits on |
| line_ret_valid | input | 1 | Cache-line fill event |
| line_ret_idx | input | LINE_W | Line that was filled |
| idle | output | 1 | Nothing to issue; clock may be gated |

## Verification
The collision of interest is an issue whose outcome is a requeue arriving in the same clock as a register write-back that wakes a different thread with a cache hit. Both land on the run-queue tail. The bench provokes this by first parking one thread, then accepting the head with a requeue while the wake-up names the parked thread's register. It judges the result purely from the issue order that follows: the requeued thread must come out before the woken one. A further cycle stacks a requeue, a wake-up, a creation and a line return together and checks all four positions in the order that follows.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    OUT_REQUEUE = 2'd0,
    OUT_SUSPEND = 2'd1,
    OUT_RETIRE  = 2'd2,
    OUT_SPARE   = 2'd3
  } issue_outcome_e;
endpackage

// File: rtl/tt_ctx_store.sv
module tt_ctx_store #(
  parameter int N_THREADS = 8,
  parameter int TID_W     = 3,
  parameter int PC_W      = 16,
  parameter int BASE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_en,
  input  logic [TID_W-1:0]  new_tid,
  input  logic [PC_W-1:0]   new_pc,
  input  logic [BASE_W-1:0] new_base,
  input  logic              upd_en,
  input  logic [TID_W-1:0]  upd_tid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [TID_W-1:0]  rd_a_tid,
  output logic [PC_W-1:0]   rd_a_pc,
  output logic [BASE_W-1:0] rd_a_base,
  input  logic [TID_W-1:0]  rd_b_tid,
  output logic [PC_W-1:0]   rd_b_pc
);
  logic [PC_W-1:0]   pc_q   [N_THREADS];
  logic [BASE_W-1:0] base_q [N_THREADS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_THREADS; i++) begin
        pc_q[i]   <= '0;
        base_q[i] <= '0;
      end
    end else begin
      if (new_en) begin
        pc_q[new_tid]   <= new_pc;
        base_q[new_tid] <= new_base;
      end
      if (upd_en) pc_q[upd_tid] <= upd_pc;
    end
  end

  assign rd_a_pc   = pc_q[rd_a_tid];
  assign rd_a_base = base_q[rd_a_tid];
  assign rd_b_pc   = pc_q[rd_b_tid];
endmodule

// File: rtl/tt_susp_slots.sv
module tt_susp_slots #(
  parameter int N_REGS = 16,
  parameter int REG_W  = 4,
  parameter int TID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TID_W-1:0] set_tid,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] look_reg,
  output logic             look_valid,
  output logic [TID_W-1:0] look_tid
);
  logic [N_REGS-1:0] vld_vec;
  logic [TID_W-1:0]  tid_arr [N_REGS];

  for (genvar r = 0; r < N_REGS; r++) begin : g_slot
    logic             vld_q;
    logic [TID_W-1:0] tid_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        tid_q <= '0;
      end else if (set_en && set_reg == REG_W'(r)) begin
        vld_q <= 1'b1;
        tid_q <= set_tid;
      end else if (clr_en && clr_reg == REG_W'(r)) begin
        vld_q <= 1'b0;
      end
    end
    assign vld_vec[r] = vld_q;
    assign tid_arr[r] = tid_q;
  end

  assign look_valid = vld_vec[look_reg];
  assign look_tid   = tid_arr[look_reg];
endmodule

// File: rtl/tt_wait_queues.sv
module tt_wait_queues #(
  parameter int N_LINES = 4,
  parameter int LINE_W  = 2,
  parameter int TID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [LINE_W-1:0] push_line,
  input  logic [TID_W-1:0]  push_tid,
  output logic              push_prev_ne,
  output logic [TID_W-1:0]  push_prev_tail,
  input  logic              drain_en,
  input  logic [LINE_W-1:0] drain_line,
  output logic              drain_ne,
  output logic [TID_W-1:0]  drain_head,
  output logic [TID_W-1:0]  drain_tail
);
  logic [N_LINES-1:0] ne_vec;
  logic [TID_W-1:0]   hd_arr [N_LINES];
  logic [TID_W-1:0]   tl_arr [N_LINES];

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic             ne_q;
    logic [TID_W-1:0] hd_q, tl_q;
    logic             push_here, drain_here;
    assign push_here  = push_en  && push_line  == LINE_W'(l);
    assign drain_here = drain_en && drain_line == LINE_W'(l);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ne_q <= 1'b0;
        hd_q <= '0;
        tl_q <= '0;
      end else if (drain_here) begin
        ne_q <= 1'b0;
      end else if (push_here) begin
        if (!ne_q) hd_q <= push_tid;
        tl_q <= push_tid;
        ne_q <= 1'b1;
      end
    end
    assign ne_vec[l] = ne_q;
    assign hd_arr[l] = hd_q;
    assign tl_arr[l] = tl_q;
  end

  logic same_line;
  assign same_line      = push_en && push_line == drain_line;
  assign push_prev_ne   = ne_vec[push_line];
  assign push_prev_tail = tl_arr[push_line];
  assign drain_ne       = ne_vec[drain_line] || same_line;
  assign drain_head     = ne_vec[drain_line] ? hd_arr[drain_line] : push_tid;
  assign drain_tail     = same_line ? push_tid : tl_arr[drain_line];
endmodule

// File: rtl/tt_thread_queues.sv
module tt_thread_queues
  import tt_pkg::*;
#(
  parameter int N_THREADS = 8,
  parameter int N_REGS    = 16,
  parameter int N_LINES   = 4,
  parameter int PC_W      = 16,
  parameter int BASE_W    = 8,
  parameter int TID_W     = $clog2(N_THREADS),
  parameter int REG_W     = $clog2(N_REGS),
  parameter int LINE_W    = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              create_valid,
  output logic              create_ready,
  input  logic [PC_W-1:0]   create_pc,
  input  logic [BASE_W-1:0] create_base,
  output logic [TID_W-1:0]  create_tid,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [TID_W-1:0]  issue_tid,
  output logic [PC_W-1:0]   issue_pc,
  output logic [BASE_W-1:0] issue_base,
  input  logic [1:0]        issue_outcome,
  input  logic [REG_W-1:0]  issue_reg,
  input  logic [PC_W-1:0]   issue_npc,
  input  logic              wake_valid,
  input  logic [REG_W-1:0]  wake_reg,
  output logic              wake_found,
  output logic [PC_W-1:0]   wake_pc,
  input  logic              wake_hit,
  input  logic [LINE_W-1:0] wake_line,
  input  logic              line_ret_valid,
  input  logic [LINE_W-1:0] line_ret_idx,
  output logic              idle
);
  // Link field shared by every queue; each thread sits in exactly one list.
  logic [TID_W-1:0] link_q [N_THREADS];
  logic [TID_W-1:0] link_n [N_THREADS];
  logic [TID_W-1:0] act_head_q, act_tail_q, free_head_q, free_tail_q;
  logic             act_ne_q, free_ne_q;
  logic [TID_W-1:0] act_head_n, act_tail_n, free_head_n, free_tail_n;
  logic             act_ne_n, free_ne_n;

  issue_outcome_e outcome;
  logic iss_fire, iss_susp, iss_retire, iss_requeue, create_fire;
  logic slot_vld, fwd_match, fwd_take, wake_hit_en, wake_miss_en, drain_go;
  logic [TID_W-1:0] slot_tid, wake_tid;
  logic             wq_prev_ne, wq_drain_ne;
  logic [TID_W-1:0] wq_prev_tail, wq_drain_head, wq_drain_tail;
  logic [PC_W-1:0]  slot_pc;

  assign outcome      = issue_outcome_e'(issue_outcome);
  assign issue_valid  = act_ne_q;
  assign issue_tid    = act_head_q;
  assign idle         = !act_ne_q;
  assign create_ready = free_ne_q;
  assign create_tid   = free_head_q;

  assign iss_fire    = act_ne_q && issue_ready;
  assign iss_susp    = iss_fire && outcome == OUT_SUSPEND;
  assign iss_retire  = iss_fire && outcome == OUT_RETIRE;
  assign iss_requeue = iss_fire && !iss_susp && !iss_retire;
  assign create_fire = create_valid && free_ne_q;

  // Wake-up resolution, including a same-cycle block on the written register.
  assign fwd_match    = iss_susp && !slot_vld && issue_reg == wake_reg;
  assign fwd_take     = wake_valid && fwd_match;
  assign wake_found   = wake_valid && (slot_vld || fwd_match);
  assign wake_tid     = slot_vld ? slot_tid : act_head_q;
  assign wake_pc      = slot_vld ? slot_pc : issue_npc;
  assign wake_hit_en  = wake_found && wake_hit;
  assign wake_miss_en = wake_found && !wake_hit;
  assign drain_go     = line_ret_valid && wq_drain_ne;

  tt_ctx_store #(.N_THREADS(N_THREADS), .TID_W(TID_W), .PC_W(PC_W), .BASE_W(BASE_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .new_en(create_fire), .new_tid(free_head_q), .new_pc(create_pc), .new_base(create_base),
    .upd_en(iss_fire && !iss_retire), .upd_tid(act_head_q), .upd_pc(issue_npc),
    .rd_a_tid(act_head_q), .rd_a_pc(issue_pc), .rd_a_base(issue_base),
    .rd_b_tid(slot_tid), .rd_b_pc(slot_pc)
  );

  tt_susp_slots #(.N_REGS(N_REGS), .REG_W(REG_W), .TID_W(TID_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .set_en(iss_susp && !fwd_take), .set_reg(issue_reg), .set_tid(act_head_q),
    .clr_en(wake_valid && slot_vld), .clr_reg(wake_reg),
    .look_reg(wake_reg), .look_valid(slot_vld), .look_tid(slot_tid)
  );

  tt_wait_queues #(.N_LINES(N_LINES), .LINE_W(LINE_W), .TID_W(TID_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .push_en(wake_miss_en), .push_line(wake_line), .push_tid(wake_tid),
    .push_prev_ne(wq_prev_ne), .push_prev_tail(wq_prev_tail),
    .drain_en(line_ret_valid), .drain_line(line_ret_idx),
    .drain_ne(wq_drain_ne), .drain_head(wq_drain_head), .drain_tail(wq_drain_tail)
  );

  // Queue update: pop, then appends in fixed order requeue, wake, create, line.
  always_comb begin
    link_n      = link_q;
    act_head_n  = act_head_q;
    act_tail_n  = act_tail_q;
    act_ne_n    = act_ne_q;
    free_head_n = free_head_q;
    free_tail_n = free_tail_q;
    free_ne_n   = free_ne_q;

    if (iss_fire) begin
      if (act_head_q == act_tail_q) act_ne_n = 1'b0;
      else                          act_head_n = link_q[act_head_q];
    end
    if (iss_requeue) begin
      if (act_ne_n) link_n[act_tail_n] = act_head_q;
      else          act_head_n = act_head_q;
      act_tail_n = act_head_q;
      act_ne_n   = 1'b1;
    end
    if (wake_hit_en) begin
      if (act_ne_n) link_n[act_tail_n] = wake_tid;
      else          act_head_n = wake_tid;
      act_tail_n = wake_tid;
      act_ne_n   = 1'b1;
    end
    if (create_fire) begin
      if (act_ne_n) link_n[act_tail_n] = free_head_q;
      else          act_head_n = free_head_q;
      act_tail_n = free_head_q;
      act_ne_n   = 1'b1;
    end
    if (drain_go) begin
      if (act_ne_n) link_n[act_tail_n] = wq_drain_head;
      else          act_head_n = wq_drain_head;
      act_tail_n = wq_drain_tail;
      act_ne_n   = 1'b1;
    end
    if (wake_miss_en && wq_prev_ne) link_n[wq_prev_tail] = wake_tid;

    if (create_fire) begin
      if (free_head_q == free_tail_q) free_ne_n = 1'b0;
      else                            free_head_n = link_q[free_head_q];
    end
    if (iss_retire) begin
      if (free_ne_n) link_n[free_tail_n] = act_head_q;
      else           free_head_n = act_head_q;
      free_tail_n = act_head_q;
      free_ne_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_THREADS; i++) link_q[i] <= TID_W'(i + 1);
      act_head_q  <= '0;
      act_tail_q  <= '0;
      act_ne_q    <= 1'b0;
      free_head_q <= '0;
      free_tail_q <= TID_W'(N_THREADS - 1);
      free_ne_q   <= 1'b1;
    end else begin
      link_q      <= link_n;
      act_head_q  <= act_head_n;
      act_tail_q  <= act_tail_n;
      act_ne_q    <= act_ne_n;
      free_head_q <= free_head_n;
      free_tail_q <= free_tail_n;
      free_ne_q   <= free_ne_n;
    end
  end
endmodule

// File: rtl/tt_thread_queues_chk.sv
module tt_thread_queues_chk #(
  parameter int TID_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             create_valid,
  input logic             create_ready,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic [TID_W-1:0] issue_tid,
  input logic [1:0]       issue_outcome,
  input logic             wake_valid,
  input logic             wake_found,
  input logic             wake_hit,
  input logic             idle
);
  assert_create_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (create_valid && create_ready) |=> !idle);

  assert_issue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_tid)));

  assert_requeue_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_outcome == 2'd0) |=> !idle);

  assert_wake_hit_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_found && wake_hit) |=> !idle);

  assert_retire_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_outcome == 2'd2) |=> create_ready);
endmodule

bind tt_thread_queues tt_thread_queues_chk #(.TID_W(TID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .create_valid(create_valid), .create_ready(create_ready),
  .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_tid(issue_tid),
  .issue_outcome(issue_outcome), .wake_valid(wake_valid), .wake_found(wake_found),
  .wake_hit(wake_hit), .idle(idle)
);

// File: tb/tt_thread_queues_tb_top.sv
`timescale 1ns/1ps
module tt_thread_queues_tb_top;
  localparam int OC_REQ = 0, OC_SUSP = 1, OC_RET = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic create_valid = 0, create_ready;
  logic [15:0] create_pc = '0;
  logic [7:0]  create_base = '0;
  logic [2:0]  create_tid;
  logic issue_valid, issue_ready = 0;
  logic [2:0]  issue_tid;
  logic [15:0] issue_pc;
  logic [7:0]  issue_base;
  logic [1:0]  issue_outcome = '0;
  logic [3:0]  issue_reg = '0;
  logic [15:0] issue_npc = '0;
  logic wake_valid = 0, wake_found, wake_hit = 0;
  logic [3:0]  wake_reg = '0;
  logic [15:0] wake_pc;
  logic [1:0]  wake_line = '0;
  logic line_ret_valid = 0;
  logic [1:0]  line_ret_idx = '0;
  logic idle;

  int checks = 0, errors = 0;
  int exp_pc [8];
  int exp_base [8];

  always #2.5 clk = ~clk;

  tt_thread_queues dut_i (
    .clk(clk), .rst_n(rst_n),
    .create_valid(create_valid), .create_ready(create_ready), .create_pc(create_pc),
    .create_base(create_base), .create_tid(create_tid),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_tid(issue_tid),
    .issue_pc(issue_pc), .issue_base(issue_base), .issue_outcome(issue_outcome),
    .issue_reg(issue_reg), .issue_npc(issue_npc),
    .wake_valid(wake_valid), .wake_reg(wake_reg), .wake_found(wake_found),
    .wake_pc(wake_pc), .wake_hit(wake_hit), .wake_line(wake_line),
    .line_ret_valid(line_ret_valid), .line_ret_idx(line_ret_idx), .idle(idle)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Commit one edge, then release every strobe and return at the falling edge.
  task automatic clk_cycle();
    @(posedge clk);
    #0.5;
    create_valid = 0; issue_ready = 0; wake_valid = 0; wake_hit = 0; line_ret_valid = 0;
    @(negedge clk);
    #0.5;
  endtask

  task automatic expect_head(input int tid, input string req);
    check(issue_valid == 1'b1, {req, " issue_valid"}, int'(issue_valid), 1);
    check(int'(issue_tid) == tid, {req, " issue_tid"}, int'(issue_tid), tid);
    check(int'(issue_pc) == exp_pc[tid], {req, " issue_pc"}, int'(issue_pc), exp_pc[tid]);
    check(int'(issue_base) == exp_base[tid], {req, " issue_base"}, int'(issue_base), exp_base[tid]);
  endtask

  task automatic pend_issue(input int tid, input int oc, input int rg, input int npc);
    issue_ready = 1; issue_outcome = 2'(oc); issue_reg = 4'(rg); issue_npc = 16'(npc);
    if (oc != OC_RET) exp_pc[tid] = npc;
    #0.5;
  endtask

  task automatic rotate(input int tid, input string req);
    expect_head(tid, req);
    pend_issue(tid, OC_REQ, 0, exp_pc[tid]);
    clk_cycle();
  endtask

  task automatic pend_create(input int pc, input int base, input int exp_tid, input string req);
    check(create_ready == 1'b1, {req, " create_ready"}, int'(create_ready), 1);
    check(int'(create_tid) == exp_tid, {req, " create_tid"}, int'(create_tid), exp_tid);
    create_valid = 1; create_pc = 16'(pc); create_base = 8'(base);
    exp_pc[exp_tid] = pc; exp_base[exp_tid] = base;
  endtask

  task automatic pend_wake(input int rg, input bit hit, input int line);
    wake_valid = 1; wake_reg = 4'(rg); wake_hit = hit; wake_line = 2'(line);
    #0.5;
  endtask

  task automatic t_reset();
    check(idle == 1'b1, "R1 idle after reset", int'(idle), 1);
    check(issue_valid == 1'b0, "R1 issue_valid after reset", int'(issue_valid), 0);
    check(create_ready == 1'b1, "R1 create_ready after reset", int'(create_ready), 1);
    check(create_tid == 3'd0, "R1 first free index", int'(create_tid), 0);
    check(idle == 1'b1, "R11 idle with empty run queue", int'(idle), 1);
  endtask

  task automatic t_create_rotate();
    pend_create('h100, 1, 0, "R2"); clk_cycle();
    check(idle == 1'b0, "R11 idle drops after creation", int'(idle), 0);
    pend_create('h200, 2, 1, "R2"); clk_cycle();
    pend_create('h300, 3, 2, "R2"); clk_cycle();
    expect_head(0, "R3");
    pend_issue(0, OC_REQ, 0, 'h104); clk_cycle();
    rotate(1, "R4");
    rotate(2, "R4");
    rotate(0, "R4 updated pc");     // order now 1,2,0
  endtask

  task automatic t_backpressure();
    for (int k = 0; k < 2; k++) begin
      expect_head(1, "R3 stalled head");
      issue_ready = 0; issue_outcome = 2'(OC_RET);
      clk_cycle();
    end
    check(int'(create_tid) == 3, "R3 stall leaves free list", int'(create_tid), 3);
    expect_head(1, "R3 head after stall");
  endtask

  task automatic t_suspend_hit();
    expect_head(1, "R5");
    pend_issue(1, OC_SUSP, 5, 'h210); clk_cycle();   // run 2,0
    expect_head(2, "R5 parked thread skipped");
    pend_wake(5, 1'b1, 0);
    check(wake_found == 1'b1, "R6 wake_found", int'(wake_found), 1);
    check(int'(wake_pc) == 'h210, "R6 wake_pc", int'(wake_pc), 'h210);
    clk_cycle();                                     // run 2,0,1
    rotate(2, "R6"); rotate(0, "R6"); rotate(1, "R6 woken at tail");
  endtask

  task automatic t_wait_line();
    expect_head(2, "R6");
    pend_issue(2, OC_SUSP, 7, exp_pc[2]); clk_cycle();   // run 0,1
    pend_wake(7, 1'b0, 3);
    check(wake_found == 1'b1, "R6 miss wake_found", int'(wake_found), 1);
    clk_cycle();                                         // line3: 2
    pend_issue(0, OC_SUSP, 8, exp_pc[0]); clk_cycle();   // run 1
    pend_wake(8, 1'b0, 3); clk_cycle();                  // line3: 2,0
    rotate(1, "R6 waiting not issued");
    expect_head(1, "R7 before return");
    line_ret_valid = 1; line_ret_idx = 2'd3; #0.5;
    clk_cycle();                                         // run 1,2,0
    rotate(1, "R7"); rotate(2, "R7 list order"); rotate(0, "R7 list order");
  endtask

  task automatic t_empty_events();
    pend_wake(9, 1'b1, 0);
    line_ret_valid = 1; line_ret_idx = 2'd1; #0.5;
    check(wake_found == 1'b0, "R6 empty slot wake_found", int'(wake_found), 0);
    clk_cycle();
    rotate(1, "R6 empty slot no change"); rotate(2, "R7 empty line no change");
    rotate(0, "R7 empty line no change");
    expect_head(1, "R7 no extra thread");
  endtask

  task automatic t_same_cycle();
    pend_issue(1, OC_SUSP, 4, exp_pc[1]); clk_cycle();   // run 2,0
    expect_head(2, "R9");
    pend_issue(2, OC_REQ, 0, exp_pc[2]);
    pend_wake(4, 1'b1, 0);
    clk_cycle();                                         // run 0,2,1
    rotate(0, "R9"); rotate(2, "R9 requeue before wake"); rotate(1, "R9 wake after requeue");
    pend_issue(0, OC_SUSP, 6, exp_pc[0]); clk_cycle();   // run 2,1
    pend_issue(2, OC_SUSP, 10, exp_pc[2]); clk_cycle();  // run 1
    pend_wake(10, 1'b0, 0); clk_cycle();                 // line0: 2
    expect_head(1, "R9 four-way");
    pend_issue(1, OC_REQ, 0, exp_pc[1]);
    pend_wake(6, 1'b1, 0);
    pend_create('h400, 4, 3, "R9");
    line_ret_valid = 1; line_ret_idx = 2'd0; #0.5;
    clk_cycle();                                         // run 1,0,3,2
    rotate(1, "R9 pos0 requeue"); rotate(0, "R9 pos1 wake");
    rotate(3, "R9 pos2 create"); rotate(2, "R9 pos3 line");
  endtask

  task automatic t_forward();
    expect_head(1, "R10");
    pend_issue(1, OC_SUSP, 11, 'h220);
    pend_wake(11, 1'b1, 0);
    check(wake_found == 1'b1, "R10 wake_found", int'(wake_found), 1);
    check(int'(wake_pc) == 'h220, "R10 wake_pc", int'(wake_pc), 'h220);
    clk_cycle();                                         // run 0,3,2,1
    rotate(0, "R10"); rotate(3, "R10"); rotate(2, "R10"); rotate(1, "R10 stays active");
    pend_wake(11, 1'b1, 0);
    check(wake_found == 1'b0, "R10 slot left empty", int'(wake_found), 0);
    clk_cycle();
  endtask

  task automatic t_retire_full();
    int order [8] = '{3, 2, 1, 4, 5, 6, 7, 0};
    expect_head(0, "R8");
    pend_issue(0, OC_RET, 0, 0); clk_cycle();            // run 3,2,1 free 4..7,0
    pend_create('h500, 5, 4, "R8"); clk_cycle();
    pend_create('h600, 6, 5, "R8"); clk_cycle();
    pend_create('h700, 7, 6, "R8"); clk_cycle();
    pend_create('h800, 8, 7, "R8"); clk_cycle();
    pend_create('h900, 9, 0, "R8 retired index reused last"); clk_cycle();
    check(create_ready == 1'b0, "R2 full table", int'(create_ready), 0);
    create_valid = 1; create_pc = 16'h0bad; #0.5;
    clk_cycle();
    for (int k = 0; k < 8; k++) begin
      expect_head(order[k], "R2 ignored create");
      pend_issue(order[k], OC_RET, 0, 0);
      clk_cycle();
    end
    check(idle == 1'b1, "R11 idle after all retired", int'(idle), 1);
    check(issue_valid == 1'b0, "R3 no issue when empty", int'(issue_valid), 0);
    check(int'(create_tid) == 3, "R8 free order follows retire order", int'(create_tid), 3);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    t_reset();
    t_create_rotate();
    t_backpressure();
    t_suspend_hit();
    t_wait_line();
    t_empty_events();
    t_same_cycle();
    t_forward();
    t_retire_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule